// File: doc/BRIEF.md
# External Bus Controller with Hold Handshake

This block sits between a small microcontroller core and its external memory pins and forms the control half of that interface. It runs from the oscillator clock and divides it by two to make the bus clock it drives out. Bus state changes only on the oscillator edges where the bus clock rises. The core offers one bus cycle at a time. Each request is tagged as program space or data space, read or write, and instruction fetch or data access. A data-space request also carries a tag that says whether its address lies outside on-chip memory.

A boot strap input is captured while reset is asserted and is then frozen. Its frozen level decides whether program-space requests stay on chip or go to the external bus. External cycles last a fixed, parameterised number of bus-clock periods. During that time the block drives an active-low read strobe and a fetch indicator.

An external master can take the bus through an active-low hold request. That request is honoured only while a configuration enable is high. The grant is given only between bus cycles. While the bus is held, new external requests stall. If the core has an interrupt that needs the bus during a hold, an active-low flag tells the external master.

Top module: `xbus_ctrl`

## Requirements
- R1: `clk_half` is low during reset, rises on the first oscillator edge after reset release and then toggles on every oscillator edge, so it runs at half the oscillator rate with a 50% duty cycle. A bus tick is an oscillator edge on which `clk_half` rises.
- R2: `strap_ext_n` is sampled on every oscillator edge while `rst_n` is low, and the last sampled value is kept. Changes on `strap_ext_n` after reset release have no effect on routing.
- R3: A program-space request (`req_prog`=1) goes to the external bus exactly when the kept strap value is 0. A data-space request (`req_prog`=0) goes to the external bus exactly when `req_ext`=1. All other requests are internal.
- R4: `mem_rd_n` goes low on the edge that accepts an external read and stays low for exactly 2*XFER_STATES oscillator cycles. It stays high for external writes and for internal requests.
- R5: `fetch_out` is high for the whole window of an external cycle that has `req_fetch`=1.
- R6: `fetch_out` stays low for external cycles with `req_fetch`=0 and for every internal request.
- R7: While `cfg_hold_en` is 0, `hold_rq_n` has no effect and `hold_ack_n` stays high.
- R8: With `cfg_hold_en`=1 and `hold_rq_n`=0, `hold_ack_n` falls on the first bus tick at which no external cycle is in progress. An external cycle that is under way always finishes first.
- R9: `hold_ack_n` rises on the first bus tick at which the hold is no longer requested (`hold_rq_n` high or `cfg_hold_en` low).
- R10: `req_ready` is high only on bus ticks outside reset. An external request is ready only when the bus is idle and no hold is being requested. An internal request is ready on any bus tick outside an external cycle, including while the bus is held. A request is accepted when `req_valid` and `req_ready` are both high.
- R11: `irq_bus_n` falls one oscillator cycle after `irq_bus_pend` is seen high while `hold_ack_n` is low. It rises one cycle after the next external request is accepted.
- R12: While `hold_ack_n` is low, `mem_rd_n` stays high and `fetch_out` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_ext_n | input | 1 | Boot strap; 0 sends program space off chip (captured during reset) |
| cfg_hold_en | input | 1 | Configuration enable for the hold handshake |
| hold_rq_n | input | 1 | Active-low bus request from an external master |
| irq_bus_pend | input | 1 | Core has a pending interrupt that needs the external bus |
| req_valid | input | 1 | Core offers a bus cycle |
| req_prog | input | 1 | 1 = program/special space, 0 = data space |
| req_ext | input | 1 | Data-space address lies outside on-chip memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_ready | output | 1 | Request accepted this edge when valid; low means stall |
| clk_half | output | 1 | Bus clock, oscillator divided by two |
| mem_rd_n | output | 1 | Active-low external read strobe |
| fetch_out | output | 1 | High during an external instruction-fetch cycle |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| irq_bus_n | output | 1 | Active-low flag: interrupt waiting for the held bus |

## Verification
The properties assume that the core holds a request and its tags steady until `req_ready` accepts it. They also assume that an instruction fetch is never tagged as a write, and that the core drops `irq_bus_pend` once the interrupt's external access has been accepted. The bench's request driver follows these rules. It changes a request only after acceptance, forces `req_fetch` low on writes, and clears the interrupt flag on the acceptance edge of an external cycle. `hold_rq_n`, `cfg_hold_en` and the strap are treated as free-running, so the stimulus toggles them at arbitrary oscillator edges, including in the middle of a bus cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_XFER = 2'd1,
    BUS_HELD = 2'd2
  } bus_st_e;

  // Routing decision: program space follows the frozen strap, data space its tag.
  function automatic logic goes_external(input logic prog,
                                         input logic ext_tag,
                                         input logic strap_n);
    return prog ? ~strap_n : ext_tag;
  endfunction

  // The hold handshake is only live while the enable bit is set.
  function automatic logic hold_wanted(input logic en, input logic rq_n);
    return en & ~rq_n;
  endfunction

  // Oscillator cycles a single external transfer keeps its strobes active.
  function automatic int unsigned xfer_osc_cycles(input int unsigned beats);
    return 2 * beats;
  endfunction

endpackage

// File: rtl/xbus_clkgen.sv
module xbus_clkgen (
  input  logic clk,
  input  logic rst_n,
  output logic clk_half,
  output logic bus_tick
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign clk_half = ph_q;
  // Next edge raises clk_half: that is where the bus advances.
  assign bus_tick = ~ph_q;
endmodule

// File: rtl/xbus_strap.sv
module xbus_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_n,
  output logic strap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_n;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned XFER_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_tick,
  input  logic hold_take,
  input  logic req_valid,
  input  logic dest_ext,
  input  logic req_write,
  input  logic req_fetch,
  output logic req_ready,
  output logic ext_start,
  output logic cyc_active,
  output logic held,
  output logic mem_rd_n,
  output logic fetch_out,
  output logic hold_ack_n
);
  localparam int unsigned CNT_W = (XFER_STATES > 1) ? $clog2(XFER_STATES) : 1;

  bus_st_e st_q;
  logic    wr_q, fe_q;
  logic    last_beat;
  logic    ext_ok, int_ok;

  always_comb begin
    ext_ok    = (st_q == BUS_IDLE) && !hold_take;
    int_ok    = (st_q != BUS_XFER);
    req_ready = rst_n && bus_tick && (dest_ext ? ext_ok : int_ok);
    ext_start = req_valid && req_ready && dest_ext;
  end

  generate
    if (XFER_STATES == 1) begin : g_single
      assign last_beat = 1'b1;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (bus_tick) begin
          if (ext_start)
            cnt_q <= CNT_W'(XFER_STATES - 1);
          else if (st_q == BUS_XFER && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      assign last_beat = (cnt_q == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= BUS_IDLE;
      wr_q <= 1'b0;
      fe_q <= 1'b0;
    end else if (bus_tick) begin
      unique case (st_q)
        BUS_IDLE: begin
          if (hold_take)
            st_q <= BUS_HELD;
          else if (ext_start) begin
            st_q <= BUS_XFER;
            wr_q <= req_write;
            fe_q <= req_fetch;
          end
        end
        BUS_XFER: begin
          if (last_beat) st_q <= hold_take ? BUS_HELD : BUS_IDLE;
        end
        BUS_HELD: begin
          if (!hold_take) st_q <= BUS_IDLE;
        end
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  assign cyc_active = (st_q == BUS_XFER);
  assign held       = (st_q == BUS_HELD);
  assign mem_rd_n   = ~(cyc_active & ~wr_q);
  assign fetch_out  = cyc_active & fe_q;
  assign hold_ack_n = ~held;
endmodule

// File: rtl/xbus_intflag.sv
module xbus_intflag (
  input  logic clk,
  input  logic rst_n,
  input  logic held,
  input  logic irq_bus_pend,
  input  logic ext_start,
  output logic irq_bus_n
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     flag_q <= 1'b0;
    else if (held && irq_bus_pend)  flag_q <= 1'b1;
    else if (ext_start)             flag_q <= 1'b0;
  end

  assign irq_bus_n = ~flag_q;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned XFER_STATES = 2
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic strap_ext_n,
  input  logic cfg_hold_en,
  input  logic hold_rq_n,
  input  logic irq_bus_pend,
  input  logic req_valid,
  input  logic req_prog,
  input  logic req_ext,
  input  logic req_write,
  input  logic req_fetch,
  output logic req_ready,
  output logic clk_half,
  output logic mem_rd_n,
  output logic fetch_out,
  output logic hold_ack_n,
  output logic irq_bus_n
);
  // Internal events, named so the checker can watch them.
  logic bus_tick;
  logic strap_q;
  logic dest_ext;
  logic hold_take;
  logic ext_start;
  logic cyc_active;
  logic held;

  assign dest_ext  = goes_external(req_prog, req_ext, strap_q);
  assign hold_take = hold_wanted(cfg_hold_en, hold_rq_n);

  xbus_clkgen u_clk (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .clk_half (clk_half),
    .bus_tick (bus_tick)
  );

  xbus_strap u_strap (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .strap_n (strap_ext_n),
    .strap_q (strap_q)
  );

  xbus_seq #(.XFER_STATES(XFER_STATES)) u_seq (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .bus_tick   (bus_tick),
    .hold_take  (hold_take),
    .req_valid  (req_valid),
    .dest_ext   (dest_ext),
    .req_write  (req_write),
    .req_fetch  (req_fetch),
    .req_ready  (req_ready),
    .ext_start  (ext_start),
    .cyc_active (cyc_active),
    .held       (held),
    .mem_rd_n   (mem_rd_n),
    .fetch_out  (fetch_out),
    .hold_ack_n (hold_ack_n)
  );

  xbus_intflag u_int (
    .clk          (clk_osc),
    .rst_n        (rst_n),
    .held         (held),
    .irq_bus_pend (irq_bus_pend),
    .ext_start    (ext_start),
    .irq_bus_n    (irq_bus_n)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_hold_en,
  input logic irq_bus_pend,
  input logic clk_half,
  input logic mem_rd_n,
  input logic fetch_out,
  input logic hold_ack_n,
  input logic irq_bus_n,
  input logic strap_q,
  input logic hold_take,
  input logic ext_start,
  input logic cyc_active
);
  a_r1_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (clk_half != $past(clk_half)));

  a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

  a_r4_read_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> cyc_active);

  a_r7_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hold_en && $past(!cfg_hold_en) && $past(hold_ack_n)) |-> hold_ack_n);

  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(hold_take));

  a_r9_release_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> $past(!hold_take));

  a_r10_no_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> !ext_start);

  a_r11_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_bus_n) |-> $past(!hold_ack_n && irq_bus_pend));

  a_r12_quiet_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (mem_rd_n && !fetch_out));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk          (clk_osc),
  .rst_n        (rst_n),
  .cfg_hold_en  (cfg_hold_en),
  .irq_bus_pend (irq_bus_pend),
  .clk_half     (clk_half),
  .mem_rd_n     (mem_rd_n),
  .fetch_out    (fetch_out),
  .hold_ack_n   (hold_ack_n),
  .irq_bus_n    (irq_bus_n),
  .strap_q      (strap_q),
  .hold_take    (hold_take),
  .ext_start    (ext_start),
  .cyc_active   (cyc_active)
);

// File: tb/test_xbus_ctrl.sv
`timescale 1ns/1ps
module test_xbus_ctrl;
  localparam int XS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_ext_n = 1'b1;
  logic cfg_hold_en = 1'b0;
  logic hold_rq_n = 1'b1;
  logic irq_bus_pend = 1'b0;
  logic req_valid = 1'b0;
  logic req_prog = 1'b0;
  logic req_ext = 1'b0;
  logic req_write = 1'b0;
  logic req_fetch = 1'b0;
  logic req_ready, clk_half, mem_rd_n, fetch_out, hold_ack_n, irq_bus_n;

  always #5 clk = ~clk;

  xbus_ctrl #(.XFER_STATES(XS)) i_xbus_ctrl (
    .clk_osc(clk), .rst_n(rst_n), .strap_ext_n(strap_ext_n),
    .cfg_hold_en(cfg_hold_en), .hold_rq_n(hold_rq_n), .irq_bus_pend(irq_bus_pend),
    .req_valid(req_valid), .req_prog(req_prog), .req_ext(req_ext),
    .req_write(req_write), .req_fetch(req_fetch), .req_ready(req_ready),
    .clk_half(clk_half), .mem_rd_n(mem_rd_n), .fetch_out(fetch_out),
    .hold_ack_n(hold_ack_n), .irq_bus_n(irq_bus_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;

  // Reference model state: plain integers, 0 idle, 1 transfer, 2 held.
  int m_ph = 0, m_st = 0, m_left = 0, m_wr = 0, m_fe = 0, m_strap = 1, m_flag = 0;
  bit req_taken = 0, irq_taken = 0;

  // Stimulus knobs (percent per oscillator cycle).
  int req_pct = 0, hold_pct = 0, irq_pct = 0, strap_pct = 0;
  bit drive_on = 0;

  function automatic bit m_goes_ext();
    if (req_prog) return (m_strap == 0);   // R3 program space follows strap
    return req_ext;                        // R3 data space follows tag
  endfunction

  function automatic bit m_ready();
    bit take;
    take = cfg_hold_en && !hold_rq_n;
    if (!rst_n || m_ph != 0) return 0;
    if (m_goes_ext()) return (m_st == 0) && !take;
    return (m_st != 1);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_ph = 0; m_st = 0; m_left = 0; m_wr = 0; m_fe = 0; m_flag = 0;
      m_strap = strap_ext_n;               // R2 captured only under reset
    end else begin
      bit take, acc, xs;
      take = cfg_hold_en && !hold_rq_n;
      acc  = req_valid && m_ready();
      xs   = acc && m_goes_ext();
      if (acc) req_taken = 1;
      if (xs && irq_bus_pend) irq_taken = 1;
      if (m_st == 2 && irq_bus_pend) m_flag = 1;
      else if (xs) m_flag = 0;
      if (m_ph == 0) begin
        case (m_st)
          0: if (take) m_st = 2;
             else if (xs) begin m_st = 1; m_left = XS; m_wr = req_write; m_fe = req_fetch; end
          1: begin m_left = m_left - 1; if (m_left == 0) m_st = take ? 2 : 0; end
          default: if (!take) m_st = 0;
        endcase
      end
      m_ph = 1 - m_ph;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Compare away from the edge, after the negedge driver has settled.
  always @(negedge clk) begin
    #3;
    if (started) begin
      chk("R1 clk_half", clk_half, 1'(m_ph));
      chk("R2 R3 R4 R12 mem_rd_n", mem_rd_n, !(m_st == 1 && m_wr == 0));
      chk("R5 R6 R12 fetch_out", fetch_out, (m_st == 1 && m_fe != 0));
      chk("R7 R8 R9 hold_ack_n", hold_ack_n, !(m_st == 2));
      chk("R10 req_ready", req_ready, m_ready());
      chk("R11 irq_bus_n", irq_bus_n, !(m_flag != 0));
    end
  end

  // Core-like driver: holds a request until taken, never a fetch that writes.
  always @(negedge clk) begin
    if (drive_on) begin
      if (req_taken) begin req_valid = 0; req_taken = 0; end
      if (!req_valid && ($urandom % 100) < req_pct) begin
        req_valid = 1;
        req_prog  = 1'($urandom % 2);
        req_ext   = 1'($urandom % 2);
        req_write = 1'($urandom % 2);
        req_fetch = req_write ? 1'b0 : 1'($urandom % 2);
      end
      if (($urandom % 100) < hold_pct) hold_rq_n = ~hold_rq_n;
      if (irq_taken) begin irq_bus_pend = 0; irq_taken = 0; end
      else if (!irq_bus_pend && ($urandom % 100) < irq_pct) irq_bus_pend = 1;
      if (($urandom % 100) < strap_pct) strap_ext_n = ~strap_ext_n;
    end
  end

  task automatic do_reset(input logic strap);
    drive_on = 0;
    @(negedge clk);
    rst_n = 0; req_valid = 0; req_taken = 0; irq_bus_pend = 0; irq_taken = 0;
    hold_rq_n = 1; strap_ext_n = strap;
    repeat (4) @(negedge clk);
    #3;
    // Reset state: R1 clock low, strobes idle, no grant, no flag
    chk("R1 reset clk_half", clk_half, 1'b0);
    chk("R4 reset mem_rd_n", mem_rd_n, 1'b1);
    chk("R6 reset fetch_out", fetch_out, 1'b0);
    chk("R8 reset hold_ack_n", hold_ack_n, 1'b1);
    chk("R11 reset irq_bus_n", irq_bus_n, 1'b1);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_phase(input int cyc, input bit hen, input int rp, input int hp,
                           input int ip, input int sp);
    cfg_hold_en = hen; req_pct = rp; hold_pct = hp; irq_pct = ip; strap_pct = sp;
    drive_on = 1;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    // Strap high: program space internal; strap toggles later must be ignored (R2, R3)
    do_reset(1'b1);
    run_phase(3000, 1'b0, 60, 0, 0, 5);
    // Hold requests toggle but the enable is off (R7)
    run_phase(3000, 1'b0, 50, 20, 10, 0);
    // Hold live: grant at boundaries, release, interrupt flag (R8, R9, R10, R11, R12)
    run_phase(4000, 1'b1, 70, 8, 15, 0);
    run_phase(3000, 1'b1, 90, 2, 30, 0);
    // Enable dropped while a hold may be granted (R7, R9)
    run_phase(2000, 1'b0, 70, 8, 15, 0);
    // Strap low: program space external, fetch windows (R3, R4, R5, R6)
    do_reset(1'b0);
    run_phase(4000, 1'b0, 80, 0, 0, 5);
    run_phase(4000, 1'b1, 80, 5, 20, 5);
    drive_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule